// File: doc/BRIEF.md
# Transmit Frame Status Classifier

This block sits on a 128-bit transmit packet stream and watches frames go by without touching them. For each frame it keeps the leading header bytes and counts the streamed bytes. Once the frame has ended it emits one status record on a one-cycle valid strobe. The record is a 40-bit word and a 7-bit error vector.

The status word holds eight frame-type flags, the frame length and the payload length. The frame length covers the destination address through the frame check sequence. The payload length counts the bytes between the length/type field and the frame check sequence. The error vector marks frames that are too long, and frames whose length field disagrees with the bytes actually carried. Byte 0 of a beat is carried on data bits 127:120, and the following bytes sit in descending order after it.

Top module: `tx_frame_status`

## Requirements
- R1: `stat_valid` is high for exactly one cycle, and only in the second cycle after an accepted end-of-packet beat. An accepted end-of-packet beat is a beat with valid and end set, start clear, while a frame is open. No other stimulus produces a pulse.
- R2: Address class sets exactly one of three bits. Bit 36 (broadcast) is set when all six destination bytes are 0xFF. Bit 37 (multicast) is set when bit 0 of destination byte 0 is 1 and the frame is not broadcast. Bit 38 (unicast) is set when bit 0 of destination byte 0 is 0.
- R3: Tag detection uses the tag identifier at bytes 12–13 and the one at bytes 16–17. Bit 32 (stacked tags) is set when bytes 12–13 hold 0x8100 or 0x88A8 and bytes 16–17 hold 0x8100. Bit 33 (tagged) is set for a single 0x8100 tag at bytes 12–13 and also for stacked tags. A lone 0x88A8 counts as an ordinary type value.
- R4: The effective type sits at byte 12 + 4×(tag count). Bit 34 (control) is set when that type is 0x8808. Within control frames, the next two bytes select the subtype: 0x0001 sets bit 35 (pause) and 0x0101 sets bit 39 (priority flow control).
- R5: Bits 31:16 hold the streamed byte count plus 4. The streamed byte count is 16 bytes per accepted beat, except the last beat, which contributes 16 minus `tx_empty`.
- R6: Bits 15:0 hold the streamed byte count minus (14 + 4×tag count), or 0 when that difference would be negative.
- R7: Error bit 2 is set when the effective type is 1500 or less and differs from the payload length. The exception is an effective type below 46 with a payload length of exactly 46, which is padding and is not an error.
- R8: Error bit 1 is set when the frame length exceeds 1518 + 4×(tag count).
- R9: Error bits 0 and 6:3 are always 0 in a record.
- R10: Some beats have no effect on any record. These are beats with valid low, beats with both start and end set, and beats without start while no frame is open.
- R11: A start beat while a frame is open abandons that frame. The abandoned frame produces no record, and the new frame is reported alone.
- R12: During reset and until the first record, `stat_valid` is 0, and `stat_word` and `stat_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Beat qualifier |
| tx_sop | input | 1 | First beat of a frame |
| tx_eop | input | 1 | Last beat of a frame |
| tx_data | input | 128 | Beat data, byte 0 in bits 127:120 |
| tx_empty | input | 4 | Unused bytes in the last beat |
| stat_valid | output | 1 | One-cycle record strobe |
| stat_word | output | 40 | Type flags [39:32], frame length [31:16], payload length [15:0] |
| stat_err | output | 7 | Bit 2 length mismatch, bit 1 oversize, others 0 |

## Verification
The embedded properties check several rules on every clock. They check the one-cycle width of the strobe and its fixed distance from an accepted end beat. They check that ignored beats never lead to a strobe, and that exactly one address-class bit is set. They also check that stacked tags imply the tagged bit, that pause and flow-control imply control, and that frame length always exceeds payload by at least the base header. Only the bench's sweeps can show the actual values: address, type and tag variants over a range of lengths. The sweeps also cover the oversize and length-field boundaries, padding, and abandoned or interrupted frames.

// File: rtl/tx_stat_pkg.sv
package tx_stat_pkg;
  localparam logic [15:0] TPID_CUST    = 16'h8100;
  localparam logic [15:0] TPID_SVC     = 16'h88A8;
  localparam logic [15:0] ETYPE_MACCTL = 16'h8808;
  localparam logic [15:0] OPC_PAUSE    = 16'h0001;
  localparam logic [15:0] OPC_PFC      = 16'h0101;

  localparam int unsigned BASE_HDR     = 14;
  localparam int unsigned TAG_BYTES    = 4;
  localparam int unsigned FCS_BYTES    = 4;
  localparam int unsigned MAX_UNTAGGED = 1518;
  localparam int unsigned MAX_LENFIELD = 1500;
  localparam int unsigned MIN_PAYLOAD  = 46;
  // header bytes needed: two tags, effective type and subtype
  localparam int unsigned HDR_KEEP     = BASE_HDR - 2 + 2 * TAG_BYTES + 4;

  // field order is the bit order 39..32 of the status word
  typedef struct packed {
    logic pfc;
    logic ucast;
    logic mcast;
    logic bcast;
    logic pause;
    logic ctrl;
    logic vlan;
    logic svlan;
  } frame_flags_t;
endpackage

// File: rtl/tx_stat_capture.sv
module tx_stat_capture
  import tx_stat_pkg::*;
#(
  parameter int unsigned DATA_W    = 128,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned HDR_BYTES = 24,
  localparam int unsigned BEAT_BYTES = DATA_W / 8,
  localparam int unsigned EMPTY_W    = $clog2(BEAT_BYTES),
  localparam int unsigned HDR_BEATS  = (HDR_BYTES + BEAT_BYTES - 1) / BEAT_BYTES,
  localparam int unsigned IDX_W      = $clog2(HDR_BEATS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_sop,
  input  logic                   in_eop,
  input  logic [DATA_W-1:0]      in_data,
  input  logic [EMPTY_W-1:0]     in_empty,
  output logic [HDR_BYTES*8-1:0] hdr,
  output logic [LEN_W-1:0]       byte_cnt,
  output logic                   frame_done,
  output logic                   pkt_open
);
  logic               in_pkt_q, in_pkt_d;
  logic [LEN_W-1:0]   cnt_q, cnt_d;
  logic [IDX_W-1:0]   idx_q, idx_d, cur_idx;
  logic               done_q, done_d;
  logic               beat_ok, start, cont, last, cnt_en, idx_en;
  logic [LEN_W-1:0]   beat_bytes;
  logic [LEN_W:0]     sum_w;

  always_comb begin
    beat_ok    = in_valid && !(in_sop && in_eop);
    start      = beat_ok && in_sop;
    cont       = beat_ok && !in_sop && in_pkt_q;
    last       = cont && in_eop;
    beat_bytes = in_eop ? (LEN_W'(BEAT_BYTES) - LEN_W'(in_empty)) : LEN_W'(BEAT_BYTES);
    sum_w      = {1'b0, cnt_q} + {1'b0, beat_bytes};

    in_pkt_d = in_pkt_q;
    if (start)     in_pkt_d = 1'b1;
    else if (last) in_pkt_d = 1'b0;

    cnt_en = start || cont;
    if (start)           cnt_d = LEN_W'(BEAT_BYTES);
    else if (sum_w[LEN_W]) cnt_d = '1;
    else                 cnt_d = sum_w[LEN_W-1:0];

    cur_idx = start ? '0 : idx_q;
    idx_en  = start || (cont && (idx_q < IDX_W'(HDR_BEATS)));
    idx_d   = cur_idx + 1'b1;
    done_d  = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      in_pkt_q <= in_pkt_d;
      done_q   <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  // one holding register per kept header byte, loaded from its beat and lane
  for (genvar i = 0; i < HDR_BYTES; i++) begin : g_hdr
    localparam int unsigned BEAT = i / BEAT_BYTES;
    localparam int unsigned LANE = i % BEAT_BYTES;
    logic [7:0] hq;
    logic       wr;
    assign wr = cnt_en && (cur_idx == IDX_W'(BEAT));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  hq <= '0;
      else if (wr) hq <= in_data[DATA_W-1-8*LANE -: 8];
    end
    assign hdr[(HDR_BYTES-i)*8-1 -: 8] = hq;
  end

  assign byte_cnt   = cnt_q;
  assign frame_done = done_q;
  assign pkt_open   = in_pkt_q;

  // R5: a finished frame spans at least two beats, one of them full
  a_r5_min_count: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (byte_cnt > LEN_W'(BEAT_BYTES)));
endmodule

// File: rtl/tx_stat_decode.sv
module tx_stat_decode
  import tx_stat_pkg::*;
#(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned HDR_BYTES = 24
) (
  input  logic [HDR_BYTES*8-1:0] hdr,
  input  logic [LEN_W-1:0]       byte_cnt,
  output frame_flags_t           flags,
  output logic [LEN_W-1:0]       frame_len,
  output logic [LEN_W-1:0]       pay_len,
  output logic                   len_err,
  output logic                   oversize
);
  logic [7:0]     hb [HDR_BYTES];
  logic [15:0]    t0, t1, etype, opcode;
  logic           stacked, single, bcast;
  logic [1:0]     ntag;
  logic [LEN_W:0] hdr_len, flen_w, max_len;

  for (genvar i = 0; i < HDR_BYTES; i++) begin : g_byte
    assign hb[i] = hdr[(HDR_BYTES-i)*8-1 -: 8];
  end

  always_comb begin
    t0      = {hb[12], hb[13]};
    t1      = {hb[16], hb[17]};
    stacked = ((t0 == TPID_CUST) || (t0 == TPID_SVC)) && (t1 == TPID_CUST);
    single  = (t0 == TPID_CUST) && !stacked;
    ntag    = stacked ? 2'd2 : (single ? 2'd1 : 2'd0);

    case (ntag)
      2'd1:    begin etype = {hb[16], hb[17]}; opcode = {hb[18], hb[19]}; end
      2'd2:    begin etype = {hb[20], hb[21]}; opcode = {hb[22], hb[23]}; end
      default: begin etype = {hb[12], hb[13]}; opcode = {hb[14], hb[15]}; end
    endcase

    bcast = &{hb[0], hb[1], hb[2], hb[3], hb[4], hb[5]};

    flags.ucast = !hb[0][0];
    flags.mcast = hb[0][0] && !bcast;
    flags.bcast = bcast;
    flags.ctrl  = (etype == ETYPE_MACCTL);
    flags.pause = flags.ctrl && (opcode == OPC_PAUSE);
    flags.pfc   = flags.ctrl && (opcode == OPC_PFC);
    flags.vlan  = (ntag != 2'd0);
    flags.svlan = stacked;

    hdr_len = (LEN_W+1)'(BASE_HDR) + (LEN_W+1)'(TAG_BYTES) * (LEN_W+1)'(ntag);
    if ({1'b0, byte_cnt} >= hdr_len) pay_len = byte_cnt - hdr_len[LEN_W-1:0];
    else                             pay_len = '0;

    flen_w    = {1'b0, byte_cnt} + (LEN_W+1)'(FCS_BYTES);
    frame_len = flen_w[LEN_W] ? '1 : flen_w[LEN_W-1:0];

    max_len  = (LEN_W+1)'(MAX_UNTAGGED) + (LEN_W+1)'(TAG_BYTES) * (LEN_W+1)'(ntag);
    oversize = flen_w > max_len;

    len_err = (32'(etype) <= MAX_LENFIELD) && (32'(pay_len) != 32'(etype)) &&
              !((32'(etype) < MIN_PAYLOAD) && (32'(pay_len) == MIN_PAYLOAD));
  end
endmodule

// File: rtl/tx_frame_status.sv
module tx_frame_status
  import tx_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned LEN_W  = 16,
  localparam int unsigned EMPTY_W = $clog2(DATA_W / 8),
  localparam int unsigned STAT_W  = $bits(frame_flags_t) + 2 * LEN_W,
  localparam int unsigned ERR_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_valid,
  input  logic               tx_sop,
  input  logic               tx_eop,
  input  logic [DATA_W-1:0]  tx_data,
  input  logic [EMPTY_W-1:0] tx_empty,
  output logic               stat_valid,
  output logic [STAT_W-1:0]  stat_word,
  output logic [ERR_W-1:0]   stat_err
);
  localparam int unsigned HDR_BYTES = HDR_KEEP;

  logic                   rst_meta, rst_sync;
  logic [HDR_BYTES*8-1:0] hdr;
  logic [LEN_W-1:0]       byte_cnt, frame_len, pay_len;
  logic                   frame_done, pkt_open, len_err, oversize;
  frame_flags_t           flags;
  logic                   valid_q, valid_d;
  logic [STAT_W-1:0]      word_q, word_d;
  logic [ERR_W-1:0]       err_q, err_d;
  logic                   rec_en;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  tx_stat_capture #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .HDR_BYTES(HDR_BYTES)
  ) u_cap (
    .clk(clk), .rst_n(rst_sync),
    .in_valid(tx_valid), .in_sop(tx_sop), .in_eop(tx_eop),
    .in_data(tx_data), .in_empty(tx_empty),
    .hdr(hdr), .byte_cnt(byte_cnt), .frame_done(frame_done), .pkt_open(pkt_open)
  );

  tx_stat_decode #(
    .LEN_W(LEN_W), .HDR_BYTES(HDR_BYTES)
  ) u_dec (
    .hdr(hdr), .byte_cnt(byte_cnt), .flags(flags),
    .frame_len(frame_len), .pay_len(pay_len),
    .len_err(len_err), .oversize(oversize)
  );

  always_comb begin
    rec_en  = frame_done;
    valid_d = frame_done;
    word_d  = {flags, frame_len, pay_len};
    err_d   = '0;
    err_d[2] = len_err;
    err_d[1] = oversize;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) valid_q <= 1'b0;
    else           valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      word_q <= '0;
      err_q  <= '0;
    end else if (rec_en) begin
      word_q <= word_d;
      err_q  <= err_d;
    end
  end

  assign stat_valid = valid_q;
  assign stat_word  = word_q;
  assign stat_err   = err_q;

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_sync)
    stat_valid |=> !stat_valid);

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_sync)
    (tx_valid && tx_eop && !tx_sop && pkt_open) |=> ##1 stat_valid);

  a_r10_ignored_beat: assert property (@(posedge clk) disable iff (!rst_sync)
    (!tx_valid || (tx_sop && tx_eop) || (!tx_sop && !pkt_open)) |=> ##1 !stat_valid);

  a_r2_one_class: assert property (@(posedge clk) disable iff (!rst_sync)
    stat_valid |-> ($countones(stat_word[38:36]) == 1));

  a_r3_stack_tagged: assert property (@(posedge clk) disable iff (!rst_sync)
    (stat_valid && stat_word[32]) |-> stat_word[33]);

  a_r4_ctrl_subtype: assert property (@(posedge clk) disable iff (!rst_sync)
    (stat_valid && (stat_word[39] || stat_word[35])) |-> (stat_word[34] && !(stat_word[39] && stat_word[35])));

  a_r6_len_relation: assert property (@(posedge clk) disable iff (!rst_sync)
    stat_valid |-> (32'(stat_word[2*LEN_W-1:LEN_W]) >= 32'(stat_word[LEN_W-1:0]) + BASE_HDR));
endmodule

// File: tb/sim_tx_frame_status.sv
module sim_tx_frame_status;
  localparam int DW = 128;
  localparam int BB = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         tx_valid, tx_sop, tx_eop;
  logic [DW-1:0] tx_data;
  logic [3:0]   tx_empty;
  logic         stat_valid;
  logic [39:0]  stat_word;
  logic [6:0]   stat_err;

  always #2.5 clk = ~clk;

  tx_frame_status u0 (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .tx_data(tx_data), .tx_empty(tx_empty),
    .stat_valid(stat_valid), .stat_word(stat_word), .stat_err(stat_err)
  );

  int checks = 0, fails = 0, spur = 0, cyc = 0;
  int qh = 0, qt = 0;
  bit finished = 0;
  logic [7:0]  fb [0:2047];
  logic [39:0] ew [0:4095];
  logic [6:0]  ee [0:4095];
  int          edue [0:4095];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic void p16(input int idx, input int val);
    fb[idx]   = 8'(val >> 8);
    fb[idx+1] = 8'(val);
  endfunction

  // expected record computed from the frame bytes and the requirements
  function automatic void model(input int n, output logic [39:0] w, output logic [6:0] e);
    logic [15:0] t0, t1, et, op;
    int tg, off, pay, fl;
    bit bc, st;
    t0 = {fb[12], fb[13]};
    t1 = {fb[16], fb[17]};
    st = ((t0 == 16'h8100) || (t0 == 16'h88A8)) && (t1 == 16'h8100);
    tg = st ? 2 : ((t0 == 16'h8100) ? 1 : 0);
    off = 12 + 4 * tg;
    et = {fb[off], fb[off+1]};
    op = {fb[off+2], fb[off+3]};
    bc = 1;
    for (int k = 0; k < 6; k++) if (fb[k] != 8'hFF) bc = 0;
    pay = n - off - 2;
    if (pay < 0) pay = 0;
    fl = n + 4;
    w[39] = (et == 16'h8808) && (op == 16'h0101);
    w[38] = !fb[0][0];
    w[37] = fb[0][0] && !bc;
    w[36] = bc;
    w[35] = (et == 16'h8808) && (op == 16'h0001);
    w[34] = (et == 16'h8808);
    w[33] = (tg > 0);
    w[32] = st;
    w[31:16] = fl[15:0];
    w[15:0]  = pay[15:0];
    e = '0;
    e[1] = fl > (1518 + 4 * tg);
    e[2] = (int'(et) <= 1500) && (pay != int'(et)) && !((int'(et) < 46) && (pay == 46));
  endfunction

  function automatic void setup(input int da, input int tk, input int n);
    for (int i = 0; i < 2048; i++) fb[i] = 8'(i * 7 + 3);
    case (da)
      0: begin fb[0]=8'h02; fb[1]=8'h11; fb[2]=8'h22; fb[3]=8'h33; fb[4]=8'h44; fb[5]=8'h55; end
      1: begin fb[0]=8'h01; fb[1]=8'h00; fb[2]=8'h5E; fb[3]=8'h00; fb[4]=8'h00; fb[5]=8'h07; end
      2: for (int k = 0; k < 6; k++) fb[k] = 8'hFF;
      default: begin for (int k = 0; k < 6; k++) fb[k] = 8'hFF; fb[5] = 8'hFE; end
    endcase
    for (int k = 6; k < 12; k++) fb[k] = 8'(8'hA0 + k);
    case (tk)
      0:  p16(12, 16'h0800);
      1:  p16(12, n - 14);
      2:  p16(12, n - 13);
      3:  p16(12, 40);
      4:  begin p16(12, 16'h8808); p16(14, 16'h0001); end
      5:  begin p16(12, 16'h8808); p16(14, 16'h0101); end
      6:  begin p16(12, 16'h8808); p16(14, 16'h0002); end
      7:  begin p16(12, 16'h8100); p16(16, 16'h0800); end
      8:  begin p16(12, 16'h88A8); p16(16, 16'h8100); p16(20, 16'h0800); end
      9:  begin p16(12, 16'h8100); p16(16, 16'h8100); p16(20, 16'h8808); p16(22, 16'h0001); end
      10: begin p16(12, 16'h88A8); p16(16, 16'h0800); end
      11: begin p16(12, 16'h8100); p16(16, n - 18); end
      12: p16(12, 1501);
      default: p16(12, 1500);
    endcase
  endfunction

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      tx_valid = 0; tx_sop = 0; tx_eop = 0; tx_data = '0; tx_empty = '0;
    end
  endtask

  // mode 1: valid-low junk beat after the first; mode 2: start+end junk beat there
  task automatic send(input int n, input int mode, input bit expect_rec);
    int nb;
    logic [39:0] w;
    logic [6:0]  e;
    nb = (n + BB - 1) / BB;
    model(n, w, e);
    for (int b = 0; b < nb; b++) begin
      logic [DW-1:0] d;
      for (int j = 0; j < BB; j++) d[DW-1-8*j -: 8] = fb[b*BB + j];
      @(negedge clk);
      tx_valid = 1; tx_sop = (b == 0); tx_eop = (b == nb - 1); tx_data = d;
      tx_empty = (b == nb - 1) ? 4'(nb * BB - n) : 4'd0;
      if (b == nb - 1 && expect_rec) begin
        ew[qt] = w; ee[qt] = e; edue[qt] = cyc + 2; qt++;
      end
      if (b == 0 && mode != 0) begin
        @(negedge clk);
        tx_valid = (mode == 2); tx_sop = 1; tx_eop = 1; tx_data = '1; tx_empty = 4'd3;
      end
    end
  endtask

  // output monitor: every record at its due cycle, nothing elsewhere
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      if (qh < qt && edue[qh] == cyc) begin
        chk(stat_valid === 1'b1, "R1", "strobe at due cycle", stat_valid, 1);
        chk(stat_word[38:36] == ew[qh][38:36], "R2", "address class", stat_word[38:36], ew[qh][38:36]);
        chk(stat_word[33:32] == ew[qh][33:32], "R3", "tag bits", stat_word[33:32], ew[qh][33:32]);
        chk({stat_word[39], stat_word[35:34]} == {ew[qh][39], ew[qh][35:34]}, "R4", "control bits",
            {stat_word[39], stat_word[35:34]}, {ew[qh][39], ew[qh][35:34]});
        chk(stat_word[31:16] == ew[qh][31:16], "R5", "frame length", stat_word[31:16], ew[qh][31:16]);
        chk(stat_word[15:0] == ew[qh][15:0], "R6", "payload length", stat_word[15:0], ew[qh][15:0]);
        chk(stat_err[2] == ee[qh][2], "R7", "length mismatch", stat_err[2], ee[qh][2]);
        chk(stat_err[1] == ee[qh][1], "R8", "oversize", stat_err[1], ee[qh][1]);
        chk({stat_err[6:3], stat_err[0]} == 5'd0, "R9", "reserved error bits", {stat_err[6:3], stat_err[0]}, 0);
        qh++;
      end else if (stat_valid !== 1'b0) begin
        spur++;
        chk(1'b0, "R1", "unexpected strobe", stat_valid, 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", cyc, 0);
    finished = 1;
    summary();
  end

  initial begin
    int s0, n, tg;
    rst_n = 0;
    tx_valid = 0; tx_sop = 0; tx_eop = 0; tx_data = '0; tx_empty = '0;
    repeat (4) @(negedge clk);
    chk(stat_valid === 1'b0, "R12", "strobe in reset", stat_valid, 0);
    chk(stat_word === 40'd0, "R12", "word in reset", stat_word, 0);
    chk(stat_err === 7'd0, "R12", "error in reset", stat_err, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(stat_valid === 1'b0 && stat_word === 40'd0 && stat_err === 7'd0, "R12", "outputs after release",
        stat_word, 0);

    // main sweep over address kinds, type kinds and lengths
    for (int da = 0; da < 4; da++)
      for (int tk = 0; tk < 14; tk++)
        for (int ni = 0; ni < 12; ni++) begin
          n = (ni < 10) ? (17 + 7 * ni) : ((ni == 10) ? 60 : 64);
          setup(da, tk, n);
          send(n, (n % 5 == 0) ? 1 : ((n % 5 == 1) ? 2 : 0), 1'b1);
          idle(ni % 3);
        end

    // R8 oversize boundary for 0, 1, 2 tags
    for (int t = 0; t < 3; t++)
      for (int d = 0; d < 2; d++) begin
        tg = t;
        n = 1514 + 4 * tg + d;
        setup(0, (tg == 0) ? 0 : ((tg == 1) ? 7 : 8), n);
        send(n, 0, 1'b1);
        idle(1);
      end

    // R7 length field at its limit
    setup(1, 1, 1514); send(1514, 0, 1'b1); idle(2);
    setup(1, 12, 1515); send(1515, 0, 1'b1); idle(2);
    setup(2, 13, 1515); send(1515, 0, 1'b1); idle(4);

    // R10 lone start+end beat and stray beats outside a frame
    s0 = spur;
    @(negedge clk); tx_valid = 1; tx_sop = 1; tx_eop = 1; tx_data = '1; tx_empty = 0;
    @(negedge clk); tx_valid = 1; tx_sop = 0; tx_eop = 1; tx_data = '1; tx_empty = 2;
    @(negedge clk); tx_valid = 1; tx_sop = 0; tx_eop = 0; tx_data = '0;
    idle(6);
    chk(spur == s0 && qh == qt, "R10", "ignored beats gave no record", spur - s0, 0);

    // R10 interrupted frames still report their own bytes only
    setup(2, 7, 45); send(45, 1, 1'b1); idle(1);
    setup(0, 9, 51); send(51, 2, 1'b1); idle(6);
    chk(spur == s0 && qh == qt, "R10", "interrupted frames reported once", qt - qh, 0);

    // R11 abandoned frame then a complete one
    setup(2, 5, 80);
    @(negedge clk); tx_valid = 1; tx_sop = 1; tx_eop = 0; tx_data = '1; tx_empty = 0;
    @(negedge clk); tx_valid = 1; tx_sop = 0; tx_eop = 0; tx_data = '1;
    setup(0, 8, 33); send(33, 0, 1'b1); idle(6);
    chk(spur == s0 && qh == qt, "R11", "only the restarted frame reported", spur - s0, 0);

    idle(10);
    chk(qh == qt, "R1", "all records delivered", qt - qh, 0);
    finished = 1;
    summary();
  end
endmodule